// File: doc/BRIEF.md
# Static Branch Direction Predictor

This decode-stage unit looks at the branch information of a single instruction and picks the direction the fetch path should follow next. An unconditional branch is taken and folded out of the instruction stream. A conditional branch whose condition is already known is folded too, and its real outcome becomes the direction. A conditional branch whose condition is still in flight gets a guess and is flagged as speculative. The guess comes from the sign of the displacement: a backward (negative) branch is guessed taken and a forward one is guessed not taken. A software hint bit can reverse that guess.

The result is registered. It appears one cycle after the input is presented, with an output valid that follows the input valid.

Top module: `sbp_top`

## Requirements
- R1: After reset, out_valid, out_taken, out_fold and out_spec are all 0.
- R2: out_valid equals the in_valid of the previous clock cycle.
- R3: If in_valid was 1 and in_uncond was 1 in the previous cycle, then out_taken=1, out_fold=1 and out_spec=0.
- R4: If in_valid was 1, in_uncond 0 and in_resolved 1 in the previous cycle, then out_fold=1, out_spec=0 and out_taken equals the previous in_cond.
- R5: If in_valid was 1, in_uncond 0 and in_resolved 0 in the previous cycle, then out_spec=1 and out_fold=0.
- R6: For a speculative branch with in_hint=0, out_taken is 1 exactly when the two's-complement in_disp was negative (its MSB set).
- R7: For a speculative branch with in_hint=1, out_taken is the inverse of the R6 guess.
- R8: A displacement of zero counts as forward, so with in_hint=0 the guess is not taken.
- R9: in_hint has no effect on out_taken for unconditional branches or resolved conditional branches.
- R10: If in_valid was 0 in the previous cycle, out_taken, out_fold and out_spec are all 0, whatever the other inputs were.
- R11: At every output cycle, out_fold and out_spec are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch is present this cycle |
| in_uncond | input | 1 | The branch is unconditional |
| in_disp | input | DISP_W | Signed branch displacement |
| in_hint | input | 1 | Software hint; reverses the static guess |
| in_resolved | input | 1 | The condition is already evaluated |
| in_cond | input | 1 | The evaluated condition (1 = taken) |
| out_valid | output | 1 | A registered decision is present |
| out_taken | output | 1 | Predicted or actual direction |
| out_fold | output | 1 | The branch is folded out without speculation |
| out_spec | output | 1 | The direction is a guess |

## Verification
The bench aims at the corners where the decision source changes:
- **Zero displacement.** A design that tested for non-positive instead of negative would guess taken.
- **Most negative displacement.** A sign test done on the wrong bit would get this one wrong.
- **Hint on folded branches.** A design that applied the hint everywhere would send an unconditional branch down the fall-through path, or flip the real outcome of a resolved branch.
- **Unconditional with resolved set.** The bench sets in_resolved together with in_uncond while in_cond is 0, so a design that checked the resolved path first would report not taken.
- **Idle cycles with active-looking inputs.** The bench drives in_valid low while the other inputs look active, so a design that did not gate on valid would leak stale or phantom decisions.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_UNCON = 2'd1,
        SRC_KNOWN = 2'd2,
        SRC_GUESS = 2'd3
    } sbp_src_e;

    typedef struct packed {
        logic valid;
        logic taken;
        logic fold;
        logic spec;
    } sbp_out_s;
endpackage

// File: rtl/sbp_classify.sv
module sbp_classify
    import sbp_pkg::*;
(
    input  logic     valid_i,
    input  logic     uncond_i,
    input  logic     resolved_i,
    output sbp_src_e src_o
);
    always_comb begin
        if (!valid_i)        src_o = SRC_NONE;
        else if (uncond_i)   src_o = SRC_UNCON;
        else if (resolved_i) src_o = SRC_KNOWN;
        else                 src_o = SRC_GUESS;
    end
endmodule

// File: rtl/sbp_static_guess.sv
module sbp_static_guess #(
    parameter int DISP_W = 16
) (
    input  logic [DISP_W-1:0] disp_i,
    input  logic              hint_i,
    output logic              guess_o
);
    localparam int SIGN_BIT = DISP_W - 1;

    logic backward;

    // Backward means negative; zero counts as forward.
    assign backward = disp_i[SIGN_BIT];
    assign guess_o  = backward ^ hint_i;
endmodule

// File: rtl/sbp_top.sv
module sbp_top
    import sbp_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_uncond,
    input  logic [DISP_W-1:0] in_disp,
    input  logic              in_hint,
    input  logic              in_resolved,
    input  logic              in_cond,
    output logic              out_valid,
    output logic              out_taken,
    output logic              out_fold,
    output logic              out_spec
);
    sbp_src_e src;
    logic     guess;
    sbp_out_s res_d, res_q;

    sbp_classify u_class (
        .valid_i    (in_valid),
        .uncond_i   (in_uncond),
        .resolved_i (in_resolved),
        .src_o      (src)
    );

    sbp_static_guess #(.DISP_W(DISP_W)) u_guess (
        .disp_i  (in_disp),
        .hint_i  (in_hint),
        .guess_o (guess)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        unique case (src)
            SRC_UNCON: begin res_d.taken = 1'b1;    res_d.fold = 1'b1; end
            SRC_KNOWN: begin res_d.taken = in_cond; res_d.fold = 1'b1; end
            SRC_GUESS: begin res_d.taken = guess;   res_d.spec = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_taken = res_q.taken;
    assign out_fold  = res_q.fold;
    assign out_spec  = res_q.spec;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));
    // R3
    uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_uncond) |=> (out_taken && out_fold && !out_spec));
    // R4
    known_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_uncond && in_resolved) |=> (out_fold && !out_spec && out_taken == $past(in_cond)));
    // R5
    guess_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_uncond && !in_resolved) |=> (out_spec && !out_fold));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_taken && !out_fold && !out_spec));
    // R11
    fold_spec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_fold, out_spec}));
endmodule

// File: tb/sbp_top_tb_top.sv
module sbp_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_uncond = 0, in_hint = 0, in_resolved = 0, in_cond = 0;
    logic [DW-1:0] in_disp = '0;
    logic out_valid, out_taken, out_fold, out_spec;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbp_top #(.DISP_W(DW)) dut_i (.*);

    function automatic logic [3:0] model(input logic v, u, r, c, h, input logic [DW-1:0] d);
        if (!v) return 4'b0000;           // {valid,taken,fold,spec}
        if (u)  return 4'b1110;
        if (r)  return {1'b1, c, 2'b10};
        return {1'b1, d[DW-1] ^ h, 2'b01};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act = {out_valid, out_taken, out_fold, out_spec};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input string req, input logic v, u, r, c, h, input logic [DW-1:0] d);
        in_valid = v; in_uncond = u; in_resolved = r; in_cond = c; in_hint = h; in_disp = d;
        @(posedge clk); #1;
        check(req, model(v, u, r, c, h, d));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        repeat (3) @(posedge clk);
        #1; check("R1", 4'b0000);
        @(negedge clk); rst_n = 1;
        drive("R3", 1, 1, 0, 0, 0, 16'h0040);
        drive("R3 R9 hint on uncond", 1, 1, 1, 0, 1, 16'hFFF0);
        drive("R4 known taken", 1, 0, 1, 1, 0, 16'h0010);
        drive("R4 R9 known not taken hint", 1, 0, 1, 0, 1, 16'hFF00);
        drive("R5 R6 backward", 1, 0, 0, 0, 0, 16'hFFFC);
        drive("R6 most negative", 1, 0, 0, 0, 0, 16'h8000);
        drive("R6 forward", 1, 0, 0, 0, 0, 16'h7FFF);
        drive("R8 zero disp", 1, 0, 0, 0, 0, 16'h0000);
        drive("R7 R8 zero disp hint", 1, 0, 0, 0, 1, 16'h0000);
        drive("R7 backward hint", 1, 0, 0, 0, 1, 16'hFFFF);
        drive("R10 idle", 0, 1, 1, 1, 1, 16'hFFFF);
        drive("R2 back to valid", 1, 0, 0, 1, 0, 16'h0004);
        for (int i = 0; i < 400; i++) begin
            logic [DW-1:0] d = DW'($urandom);
            drive("R2 R11 random", 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), d);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule